// File: doc/BRIEF.md
# Indirect Shared Register Access Bridge

This block lets a host reach a bank of internal shared registers through only two host-visible words: a command word and a data word. The host writes the command word with a target offset and an operation code. The bridge then runs a single read or write on an internal register bus. It holds the request until the internal side returns a ready pulse.

For a read, the host writes the command word and later takes the result from the data word. For a write, the host loads the data word first and then writes the command word with the write code. The bridge runs from its own clock and reset and needs nothing from the main processing domain, so it still works while that domain is powered down. A busy output marks the period during which an access is in flight.

Command word layout: bits 15:0 carry the target offset and bits 29:28 carry the operation code. Code 2 is a read and code 3 is a write. Codes 0 and 1 start nothing. The other bits are stored for readback but have no effect.

Top module: `shr_indirect_bridge`

## Requirements
- R1: After a synchronous active-low reset, busy and ib_req are 0, and both host words read back as 0.
- R2: A command write (hst_sel=0) with code 2 in bits 29:28, made while not busy, drives ib_req=1 and ib_we=0 in the next cycle, with ib_addr equal to bits 15:0 of the written word. Bits outside 15:0 and 29:28 do not change the access.
- R3: A command write with code 3, made while not busy, drives ib_req=1 and ib_we=1 in the next cycle. ib_wdata carries the data word as it stood when the command was written, and that value lands at the target.
- R4: A command write with code 0 or 1 raises no request and leaves the data word unchanged. The written word is still stored as the command word.
- R5: busy and ib_req are high from the cycle after an accepted command until the cycle after the edge at which ib_ready is sampled high. ib_addr, ib_we and ib_wdata stay stable while the bridge waits.
- R6: A command write made while busy is ignored. The command word keeps its value and no further access is started.
- R7: A read result is captured from ib_rdata at the ready edge and shows on the data word from the next cycle. Until then, reading the data word (hst_sel=1) returns its previous value.
- R8: If a host data-word write and a read completion fall in the same cycle, the read result is the value that is kept.
- R9: ib_ready is ignored while no request is outstanding.
- R10: A host data-word write updates the data word in the next cycle, even while busy. It does not change the ib_wdata of a write already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wen | input | 1 | Host write strobe |
| hst_sel | input | 1 | Word select: 0 command word, 1 data word |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Readback of the selected word |
| busy | output | 1 | An internal access is outstanding |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus direction: 1 write, 0 read |
| ib_addr | output | 16 | Internal register offset |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data, valid with ib_ready |
| ib_ready | input | 1 | Internal completion pulse |

## Verification
Every result is due exactly one clock after the edge that causes it:
- ib_req, ib_addr, ib_we and busy follow one cycle after the accepted command write.
- The request drops, and a read result shows on the data word, one cycle after the ready edge.
- A host data write shows one cycle after it is made.

The bench keeps a behavioural model that it steps on each rising edge using the inputs sampled there. It compares every output a few nanoseconds after that edge, once the registers have settled. Inputs are changed only on falling edges, so the model and the design see the same values. Directed checks then look at the same ports after each scenario finishes. These scenarios cover codes 0 and 1, a command written while busy, a stray ready pulse and a collision between ready and a host data write.

// File: rtl/shr_bridge_pkg.sv
// Package: shared field positions, op codes and FSM states of the bridge.
// Assumes the op field is two bits wide and sits above the offset field.
package shr_bridge_pkg;

    // Operation codes carried in the command word
    typedef enum logic [1:0] {
        OP_IDLE0 = 2'd0,
        OP_IDLE1 = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } shr_op_e;

    // Host word select encoding
    localparam logic SEL_CMD  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    // Internal bus master states
    typedef enum logic {
        BM_IDLE = 1'b0,
        BM_WAIT = 1'b1
    } bm_state_e;

endpackage

// File: rtl/shr_op_decode.sv
// Module: decodes a host command-word write into an accept strobe and
// read/write start strobes. Assumes the caller supplies the op field and
// offset already sliced out of the host data.
module shr_op_decode
    import shr_bridge_pkg::*;
#(
    parameter int OFFS_W = 16
) (
    input  logic              hst_wen,
    input  logic              hst_sel,
    input  logic [1:0]        op_field,
    input  logic [OFFS_W-1:0] offs_field,
    input  logic              busy,
    output logic              cmd_accept,
    output logic              start_rd,
    output logic              start_wr,
    output logic [OFFS_W-1:0] start_offs
);

    shr_op_e op;

    // Purpose: qualify a command write and split it by operation code
    always_comb begin
        op         = shr_op_e'(op_field);
        cmd_accept = hst_wen && (hst_sel == SEL_CMD) && !busy;
        start_rd   = cmd_accept && (op == OP_READ);
        start_wr   = cmd_accept && (op == OP_WRITE);
        start_offs = offs_field;
    end

endmodule

// File: rtl/shr_host_regs.sv
// Module: holds the host-visible command and data words and drives the
// readback mux. Assumes a completed read always takes priority over a
// host data-word write in the same cycle.
module shr_host_regs
    import shr_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wen,
    input  logic              hst_sel,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              cmd_accept,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_result,
    output logic [DATA_W-1:0] data_word,
    output logic [DATA_W-1:0] hst_rdata
);

    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              data_wr;

    assign data_wr = hst_wen && (hst_sel == SEL_DATA);

    // Purpose: store the command word when the decode accepts it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_accept) begin
            cmd_q <= hst_wdata;
        end
    end

    // Purpose: update the data word; a read result beats a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_result;
        end else if (data_wr) begin
            data_q <= hst_wdata;
        end
    end

    // Purpose: readback of the selected host word
    always_comb begin
        hst_rdata = (hst_sel == SEL_DATA) ? data_q : cmd_q;
    end

    assign data_word = data_q;

    AST_BUSY_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_wen && (hst_sel == SEL_CMD)) |=> $stable(cmd_q)); // R6

    AST_RESULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (data_q == $past(rd_result))); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_done && !data_wr) |=> $stable(data_q)); // R4

endmodule

// File: rtl/shr_bus_master.sv
// Module: single-outstanding internal register bus master. It latches the
// offset, direction and write data at start, holds the request until ready,
// and reports completion. Assumes one request/ready pair and one clock.
module shr_bus_master
    import shr_bridge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFFS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [OFFS_W-1:0] start_offs,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              ib_ready,
    output logic              ib_req,
    output logic              ib_we,
    output logic [OFFS_W-1:0] ib_addr,
    output logic [DATA_W-1:0] ib_wdata,
    output logic              busy,
    output logic              rd_done
);

    bm_state_e         state_q;
    logic              we_q;
    logic [OFFS_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done;

    assign done = (state_q == BM_WAIT) && ib_ready;

    // Purpose: request state machine, idle until start, wait until ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BM_IDLE;
        end else begin
            case (state_q)
                BM_IDLE: if (start_rd || start_wr) state_q <= BM_WAIT;
                BM_WAIT: if (ib_ready) state_q <= BM_IDLE;
                default: state_q <= BM_IDLE;
            endcase
        end
    end

    // Purpose: capture the access attributes when an access starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if ((state_q == BM_IDLE) && (start_rd || start_wr)) begin
            we_q    <= start_wr;
            addr_q  <= start_offs;
            wdata_q <= start_wdata;
        end
    end

    assign ib_req   = (state_q == BM_WAIT);
    assign busy     = (state_q == BM_WAIT);
    assign ib_we    = we_q;
    assign ib_addr  = addr_q;
    assign ib_wdata = wdata_q;
    assign rd_done  = done && !we_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ready) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata))); // R5

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ready) |=> !ib_req); // R5

    AST_STRAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && ib_ready) |-> !rd_done); // R9

endmodule

// File: rtl/shr_indirect_bridge.sv
// Module: top of the indirect shared register bridge. It connects the
// command decode, the host word registers and the internal bus master.
// Assumes the host and internal bus share one clock and reset.
module shr_indirect_bridge
    import shr_bridge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFFS_W = 16,
    parameter int OP_LSB = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wen,
    input  logic              hst_sel,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              busy,
    output logic              ib_req,
    output logic              ib_we,
    output logic [OFFS_W-1:0] ib_addr,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic [DATA_W-1:0] ib_rdata,
    input  logic              ib_ready
);

    localparam int OP_MSB = OP_LSB + 1;

    logic              cmd_accept;
    logic              start_rd;
    logic              start_wr;
    logic [OFFS_W-1:0] start_offs;
    logic [DATA_W-1:0] data_word;
    logic              rd_done;

    shr_op_decode #(.OFFS_W(OFFS_W)) u_dec (
        .hst_wen    (hst_wen),
        .hst_sel    (hst_sel),
        .op_field   (hst_wdata[OP_MSB:OP_LSB]),
        .offs_field (hst_wdata[OFFS_W-1:0]),
        .busy       (busy),
        .cmd_accept (cmd_accept),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .start_offs (start_offs)
    );

    shr_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_wen    (hst_wen),
        .hst_sel    (hst_sel),
        .hst_wdata  (hst_wdata),
        .cmd_accept (cmd_accept),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_result  (ib_rdata),
        .data_word  (data_word),
        .hst_rdata  (hst_rdata)
    );

    shr_bus_master #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_bm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_rd    (start_rd),
        .start_wr    (start_wr),
        .start_offs  (start_offs),
        .start_wdata (data_word),
        .ib_ready    (ib_ready),
        .ib_req      (ib_req),
        .ib_we       (ib_we),
        .ib_addr     (ib_addr),
        .ib_wdata    (ib_wdata),
        .busy        (busy),
        .rd_done     (rd_done)
    );

    AST_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hst_wen && (hst_sel == SEL_CMD) && (hst_wdata[OP_MSB:OP_LSB] == 2'd2))
        |=> (ib_req && !ib_we && (ib_addr == $past(hst_wdata[OFFS_W-1:0])))); // R2

    AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hst_wen && (hst_sel == SEL_CMD) && (hst_wdata[OP_MSB:OP_LSB] == 2'd3))
        |=> (ib_req && ib_we && (ib_wdata == $past(data_word)))); // R3

    AST_NOOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hst_wen && (hst_sel == SEL_CMD) && !hst_wdata[OP_MSB]) |=> !ib_req); // R4

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ib_ready) |=> ($stable(ib_addr) && busy)); // R6

endmodule

// File: tb/shr_indirect_bridge_bench.sv
module shr_indirect_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wen = 1'b0;
    logic        hst_sel = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        busy;
    logic        ib_req;
    logic        ib_we;
    logic [15:0] ib_addr;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata = 32'hDEAD_BEEF;
    logic        ib_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    shr_indirect_bridge u_shr_indirect_bridge (
        .clk(clk), .rst_n(rst_n), .hst_wen(hst_wen), .hst_sel(hst_sel),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .busy(busy),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_rdata(ib_rdata), .ib_ready(ib_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- internal bus responder ----------------
    logic [31:0] mem [logic [15:0]];
    int lat = 2;
    int cnt = 0;
    bit armed = 0;

    function automatic logic [31:0] peek(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return {~a, a};
    endfunction

    always @(negedge clk) begin
        ib_ready = 1'b0;
        ib_rdata = 32'hDEAD_BEEF;
        if (ib_req) begin
            if (!armed) begin armed = 1; cnt = lat; end
            if (cnt == 0) begin
                ib_ready = 1'b1;
                armed = 0;
                if (ib_we) mem[ib_addr] = ib_wdata;
                else ib_rdata = peek(ib_addr);
            end else cnt--;
        end
    end

    // ---------------- behavioural reference model ----------------
    logic        m_req = 0, m_we = 0;
    logic [15:0] m_addr = 0;
    logic [31:0] m_wdata = 0, m_cmd = 0, m_data = 0;

    always @(posedge clk) begin
        logic        acc, fin;
        logic [1:0]  op;
        if (!rst_n) begin
            m_req = 0; m_we = 0; m_addr = 0; m_wdata = 0; m_cmd = 0; m_data = 0;
        end else begin
            acc = hst_wen && !hst_sel && !m_req;
            op  = hst_wdata[29:28];
            fin = m_req && ib_ready;
            if (fin && !m_we) m_data = ib_rdata;
            else if (hst_wen && hst_sel) m_data = hst_wdata;
            if (acc) m_cmd = hst_wdata;
            if (acc && op[1]) begin
                m_req = 1; m_we = op[0]; m_addr = hst_wdata[15:0]; m_wdata = m_wdata_src;
            end else if (fin) m_req = 0;
        end
    end
    // data word before this edge's update feeds the write operand
    logic [31:0] m_wdata_src;
    always @(negedge clk) m_wdata_src = m_data;

    // per-cycle comparison, after the registers settle
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            chk("R5 busy", {31'd0, busy}, {31'd0, m_req});
            chk("R2 ib_req", {31'd0, ib_req}, {31'd0, m_req});
            chk("R2 ib_addr", {16'd0, ib_addr}, {16'd0, m_addr});
            chk("R3 ib_we", {31'd0, ib_we}, {31'd0, m_we});
            chk("R10 ib_wdata", ib_wdata, m_wdata);
            chk(hst_sel ? "R7 data word" : "R6 command word", hst_rdata, hst_sel ? m_data : m_cmd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic hwr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        hst_wen = 1; hst_sel = sel; hst_wdata = d;
        @(negedge clk);
        hst_wen = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic look(input logic sel, input string req, input logic [31:0] exp);
        hst_sel = sel; #1;
        chk(req, hst_rdata, exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R1 reset state
        look(1, "R1 data after reset", 32'h0);
        look(0, "R1 command after reset", 32'h0);
        chk("R1 busy after reset", {31'd0, busy}, 32'h0);
        chk("R1 ib_req after reset", {31'd0, ib_req}, 32'h0);
        @(negedge clk); rst_n = 1;
        idle(2);

        // R2/R7 plain read with upper junk bits, latency 3
        lat = 3;
        hwr(0, 32'hC000_0000 | (32'd2 << 28) | 32'h0FF0_0000 | 32'h0ABC);
        chk("R2 ib_addr junk bits", {16'd0, ib_addr}, 32'h0ABC);
        look(1, "R7 data before result", 32'h0);
        wait_idle();
        look(1, "R7 read result", peek(16'h0ABC));

        // R3/R10 write, data changed while in flight
        lat = 2;
        hwr(1, 32'hCAFE_F00D);
        hwr(0, (32'd3 << 28) | 32'hFFFF);
        hwr(1, 32'h1111_2222);
        chk("R10 in-flight operand", ib_wdata, 32'hCAFE_F00D);
        wait_idle();
        look(1, "R10 data word updated", 32'h1111_2222);
        hwr(0, (32'd2 << 28) | 32'hFFFF);
        wait_idle();
        look(1, "R3 write landed", 32'hCAFE_F00D);

        // R4 op codes 0 and 1
        hwr(0, (32'd0 << 28) | 32'h0042);
        idle(2);
        chk("R4 op0 no request", {31'd0, ib_req}, 32'h0);
        hwr(0, (32'd1 << 28) | 32'h0043);
        idle(2);
        chk("R4 op1 no request", {31'd0, ib_req}, 32'h0);
        look(1, "R4 data unchanged", 32'hCAFE_F00D);
        look(0, "R4 command stored", (32'd1 << 28) | 32'h0043);

        // R6 command while busy
        lat = 4;
        hwr(0, (32'd2 << 28) | 32'h0010);
        hwr(0, (32'd3 << 28) | 32'h0020);
        look(0, "R6 command kept", (32'd2 << 28) | 32'h0010);
        chk("R6 address kept", {16'd0, ib_addr}, 32'h0010);
        wait_idle();
        idle(3);
        chk("R6 no second access", {31'd0, ib_req}, 32'h0);
        look(1, "R6 first read result", peek(16'h0010));

        // R9 stray ready
        @(negedge clk); #1; ib_ready = 1; ib_rdata = 32'h5555_5555;
        idle(2);
        look(1, "R9 stray ready ignored", peek(16'h0010));
        chk("R9 no request", {31'd0, ib_req}, 32'h0);

        // R8 collision: ready (lat 0) in the same cycle as a data write
        lat = 0;
        @(negedge clk); hst_wen = 1; hst_sel = 0; hst_wdata = (32'd2 << 28) | 32'h0077;
        @(negedge clk); hst_wen = 1; hst_sel = 1; hst_wdata = 32'h9999_9999;
        @(negedge clk); hst_wen = 0;
        look(1, "R8 read result wins", peek(16'h0077));

        // R2 boundary offset 0
        lat = 1;
        hwr(0, (32'd2 << 28) | 32'h0000);
        chk("R2 offset zero", {16'd0, ib_addr}, 32'h0);
        wait_idle();
        look(1, "R7 offset zero result", peek(16'h0000));
        idle(4);

        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done_flag) begin
            done_flag = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule